// File: doc/BRIEF.md
# Synchronous ROM and Flash Read Sequencer

This block performs single read accesses to a pair of synchronous static memory partitions populated either with synchronous mask ROM or with a fast flash device that does not follow SDRAM timing. A requester presents a row address, a column address and a configuration word together with a request strobe. The sequencer then puts an activate command on the memory command lines, waits out the row latency, issues a read command, waits out the column latency, captures the data bus and hands the word back with a one-cycle valid pulse.

The configuration word selects the memory type, the row and column latency codes, an enable bit and a half-rate option. With the half-rate option the external memory clock runs at half the internal clock, so each command is held for two internal cycles and every external-cycle wait counts double. The latency codes are validated against the selected memory type; an access with the enable bit clear, an unknown memory type or a reserved column code is refused with an error pulse and never reaches the memory. Only one access is in flight at a time. Configuration should always err toward the longer column latency when the device requirement is uncertain.

Top module: `srom_read_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `memCmd` is NOP, `reqReady` is 1, and `rdValid` and `rdError` are 0.
- R2: The configuration word packs enable in bit 0, half-rate in bit 1, memory type in bits 3:2 (00 = synchronous ROM, 10 = fast flash), row code in bits 6:4 and column code in bits 9:7. Commands are encoded NOP = 00, ACT = 01, READ = 10; `memAddr` carries the zero-extended row while ACT is shown, the zero-extended column while READ is shown, and zero otherwise.
- R3: In ROM mode the first READ cycle comes (row code + 1) × M cycles after the first ACT cycle, where M is 1 at full rate and 2 at half rate; the cycles in between show NOP.
- R4: In flash mode the row code is ignored and the first READ cycle comes M cycles after the first ACT cycle.
- R5: With column code c (latency c + 1 external cycles), the data bus is sampled in the cycle (c + 1) × M after the first READ cycle, and `rdData` presents that value in the next cycle together with a single-cycle `rdValid`.
- R6: ACT and READ are each shown for exactly M consecutive cycles; every other cycle shows NOP.
- R7: A request is rejected if enable is 0, the type is 01 or 11, a ROM access uses column code 000, 001, 110 or 111, or a flash access uses column code 000, 001 or 111; `rdError` is then 1 in the cycle after acceptance, no command is issued and `reqReady` stays 1.
- R8: `reqReady` is 0 from the cycle after an access is accepted up to the cycle in which `rdValid` is shown, where it is 1 again; requests presented while it is 0 are ignored.
- R9: The configuration word is sampled when a request is accepted; changing it during an access does not alter that access's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal memory clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Read request strobe |
| reqReady | output | 1 | Sequencer idle and able to take a request |
| reqRow | input | ROW_W | Row address of the request |
| reqCol | input | COL_W | Column address of the request |
| cfgWord | input | 10 | Type, latency codes, enable and half-rate option |
| memCmd | output | 2 | Command to the memory: NOP, ACT or READ |
| memAddr | output | max(ROW_W, COL_W) | Address shown with the current command |
| memData | input | DATA_W | Data bus from the memory |
| rdData | output | DATA_W | Captured read word |
| rdValid | output | 1 | One-cycle pulse marking `rdData` valid |
| rdError | output | 1 | One-cycle pulse marking a refused request |

## Verification
The hardest case to reach from the ports is a configuration change landing in the middle of a running access, combined with requests held high through the busy window, because both must leave the access already in flight untouched. The stimulus sweeps every row code and every legal column code in both memory types and both clock rates, then holds the request strobe high across several back-to-back accesses while the row changes each cycle, and separately rewrites the configuration word to a flash, half-rate setting a few cycles after a ROM access starts. The bench model schedules each access from the word it saw at acceptance and compares command, address, ready, valid, data and error on every clock, with a data bus that changes every cycle so that an off-by-one sample point shows up as a data mismatch.

// File: rtl/srom_seq_pkg.sv
package srom_seq_pkg;

  // Width of each latency code field
  localparam int CODE_W  = 3;
  // Configuration word width: colCode, rowCode, memType, halfRate, enable
  localparam int CFG_W   = 2 * CODE_W + 4;
  // Longest counter preload: largest code value doubled for half rate
  localparam int MAX_LEN = 2 * ((1 << CODE_W) - 1);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  localparam logic [1:0] TYPE_ROM   = 2'b00;
  localparam logic [1:0] TYPE_FLASH = 2'b10;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_ACT  = 2'b01,
    CMD_READ = 2'b10
  } memCmd_e;

  typedef struct packed {
    logic [CODE_W-1:0] colCode;
    logic [CODE_W-1:0] rowCode;
    logic [1:0]        memType;
    logic              halfRate;
    logic              enable;
  } cfg_t;

  // Which wait phase the counter is preloaded for
  typedef enum logic [1:0] {
    PH_ACT   = 2'd0,
    PH_RWAIT = 2'd1,
    PH_READ  = 2'd2,
    PH_CWAIT = 2'd3
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   capture;
    logic   load;
    phase_e loadSel;
    logic   latch;
    logic   reject;
  } strobe_t;

endpackage

// File: rtl/srom_seq_ctrl.sv
module srom_seq_ctrl
  import srom_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    cfgOk,
  input  logic    rowSkip,
  input  logic    cntZero,
  output strobe_t strobes,
  output memCmd_e memCmd,
  output logic    reqReady
);

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ACT   = 3'd1,
    S_RWAIT = 3'd2,
    S_READ  = 3'd3,
    S_CWAIT = 3'd4
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState       = state;
    strobes.capture = 1'b0;
    strobes.load    = 1'b0;
    strobes.loadSel = PH_ACT;
    strobes.latch   = 1'b0;
    strobes.reject  = 1'b0;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          if (cfgOk) begin
            strobes.capture = 1'b1;
            strobes.load    = 1'b1;
            strobes.loadSel = PH_ACT;
            nextState       = S_ACT;
          end else begin
            strobes.reject = 1'b1;
          end
        end
      end
      S_ACT: begin
        if (cntZero) begin
          strobes.load = 1'b1;
          if (rowSkip) begin
            strobes.loadSel = PH_READ;
            nextState       = S_READ;
          end else begin
            strobes.loadSel = PH_RWAIT;
            nextState       = S_RWAIT;
          end
        end
      end
      S_RWAIT: begin
        if (cntZero) begin
          strobes.load    = 1'b1;
          strobes.loadSel = PH_READ;
          nextState       = S_READ;
        end
      end
      S_READ: begin
        if (cntZero) begin
          strobes.load    = 1'b1;
          strobes.loadSel = PH_CWAIT;
          nextState       = S_CWAIT;
        end
      end
      S_CWAIT: begin
        if (cntZero) begin
          strobes.latch = 1'b1;
          nextState     = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_comb begin
    case (state)
      S_ACT:   memCmd = CMD_ACT;
      S_READ:  memCmd = CMD_READ;
      default: memCmd = CMD_NOP;
    endcase
  end

  assign reqReady = (state == S_IDLE);

  // An accepted request takes the sequencer busy on the next cycle
  assert_accept_drops_ready_R8: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && cfgOk) |=> !reqReady);

  // A refused request leaves the sequencer idle with no command
  assert_reject_no_command_R7: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && !cfgOk) |=> (reqReady && memCmd == CMD_NOP));

endmodule

// File: rtl/srom_seq_dp.sv
module srom_seq_dp
  import srom_seq_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobes,
  input  memCmd_e           memCmd,
  input  cfg_t              cfgIn,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] memData,
  output logic              cfgOk,
  output logic              rowSkip,
  output logic              cntZero,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              rdError
);

  // Counter preload (length minus one, except the column wait which ends
  // on its sample cycle) for a phase, doubled at half rate.
  function automatic logic [CNT_W-1:0] phaseLen(
    input logic              half,
    input logic [CODE_W-1:0] rowCode,
    input logic [CODE_W-1:0] colCode,
    input phase_e            sel
  );
    logic [CNT_W-1:0] base;
    case (sel)
      PH_RWAIT: base = CNT_W'(rowCode);
      PH_CWAIT: base = CNT_W'(colCode);
      default:  base = CNT_W'(1);
    endcase
    if (half) base = base << 1;
    return (sel == PH_CWAIT) ? base : base - CNT_W'(1);
  endfunction

  function automatic logic colLegal(input logic [1:0] memType,
                                    input logic [CODE_W-1:0] colCode);
    logic ok;
    ok = 1'b0;
    if (memType == TYPE_ROM)
      ok = (colCode >= CODE_W'(2)) && (colCode <= CODE_W'(5));
    else if (memType == TYPE_FLASH)
      ok = (colCode >= CODE_W'(2)) && (colCode <= CODE_W'(6));
    return ok;
  endfunction

  logic              heldHalf;
  logic [CODE_W-1:0] heldRowCode;
  logic [CODE_W-1:0] heldColCode;
  logic              heldRowSkip;
  logic [ROW_W-1:0]  rowHeld;
  logic [COL_W-1:0]  colHeld;
  logic [CNT_W-1:0]  cnt;

  logic              useHalf;
  logic [CODE_W-1:0] useRowCode;
  logic [CODE_W-1:0] useColCode;

  assign cfgOk = cfgIn.enable && colLegal(cfgIn.memType, cfgIn.colCode);

  // Capture of configuration and address at acceptance
  always_ff @(posedge clk) begin
    if (rst) begin
      heldHalf    <= 1'b0;
      heldRowCode <= '0;
      heldColCode <= '0;
      heldRowSkip <= 1'b0;
      rowHeld     <= '0;
      colHeld     <= '0;
    end else if (strobes.capture) begin
      heldHalf    <= cfgIn.halfRate;
      heldRowCode <= cfgIn.rowCode;
      heldColCode <= cfgIn.colCode;
      heldRowSkip <= (cfgIn.memType == TYPE_FLASH) || (cfgIn.rowCode == '0);
      rowHeld     <= reqRow;
      colHeld     <= reqCol;
    end
  end

  assign rowSkip = heldRowSkip;

  // The first preload happens on the capture edge, so it reads live values
  assign useHalf    = strobes.capture ? cfgIn.halfRate : heldHalf;
  assign useRowCode = strobes.capture ? cfgIn.rowCode  : heldRowCode;
  assign useColCode = strobes.capture ? cfgIn.colCode  : heldColCode;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (strobes.load)
      cnt <= phaseLen(useHalf, useRowCode, useColCode, strobes.loadSel);
    else if (cnt != '0)
      cnt <= cnt - CNT_W'(1);
  end

  assign cntZero = (cnt == '0);

  always_comb begin
    case (memCmd)
      CMD_ACT:  memAddr = ADDR_W'(rowHeld);
      CMD_READ: memAddr = ADDR_W'(colHeld);
      default:  memAddr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData  <= '0;
      rdValid <= 1'b0;
      rdError <= 1'b0;
    end else begin
      if (strobes.latch) rdData <= memData;
      rdValid <= strobes.latch;
      rdError <= strobes.reject;
    end
  end

  // A data return and a refusal never share a cycle
  assert_valid_error_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rdValid, rdError}));

  // Held configuration only moves on an acceptance
  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    !strobes.capture |=> $stable({heldHalf, heldRowCode, heldColCode, heldRowSkip}));

endmodule

// File: rtl/srom_read_seq.sv
module srom_read_seq
  import srom_seq_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DATA_W = 32,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [CFG_W-1:0]  cfgWord,
  output logic [1:0]        memCmd,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              rdError
);

  strobe_t strobes;
  memCmd_e cmdInt;
  logic    cfgOk;
  logic    rowSkip;
  logic    cntZero;
  cfg_t    cfgIn;

  assign cfgIn  = cfg_t'(cfgWord);
  assign memCmd = cmdInt;

  srom_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .cfgOk    (cfgOk),
    .rowSkip  (rowSkip),
    .cntZero  (cntZero),
    .strobes  (strobes),
    .memCmd   (cmdInt),
    .reqReady (reqReady)
  );

  srom_seq_dp #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .memCmd  (cmdInt),
    .cfgIn   (cfgIn),
    .reqRow  (reqRow),
    .reqCol  (reqCol),
    .memData (memData),
    .cfgOk   (cfgOk),
    .rowSkip (rowSkip),
    .cntZero (cntZero),
    .memAddr (memAddr),
    .rdData  (rdData),
    .rdValid (rdValid),
    .rdError (rdError)
  );

  // Reset leaves the sequencer idle with a NOP on the command lines
  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (memCmd == 2'b00 && reqReady && !rdValid && !rdError));

endmodule

// File: tb/srom_read_seq_tb.sv
module srom_read_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W  = 13;
  localparam int COL_W  = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 13;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reqValid = 1'b0;
  logic [ROW_W-1:0]  reqRow = '0;
  logic [COL_W-1:0]  reqCol = '0;
  logic [9:0]        cfgWord = '0;
  logic [DATA_W-1:0] memData = '0;
  logic              reqReady;
  logic [1:0]        memCmd;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] rdData;
  logic              rdValid;
  logic              rdError;

  srom_read_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqRow(reqRow), .reqCol(reqCol), .cfgWord(cfgWord),
    .memCmd(memCmd), .memAddr(memAddr), .memData(memData),
    .rdData(rdData), .rdValid(rdValid), .rdError(rdError)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  int busyEnd = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int                expCmd[int];
  logic [ADDR_W-1:0] expAddr[int];
  string             expTag[int];
  bit                expValid[int];
  logic [DATA_W-1:0] expData[int];
  bit                expErr[int];

  function automatic logic [DATA_W-1:0] pat(int k);
    return (32'(k) * 32'h9E3779B1) ^ 32'h0F0F1234;
  endfunction

  function automatic logic [9:0] mk(int en, int half, int typ, int rc, int cc);
    return {3'(cc), 3'(rc), 2'(typ), 1'(half), 1'(en)};
  endfunction

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, exp);
    end
  endtask

  // Behavioural model: plan an accepted access from the word seen at acceptance
  function automatic void schedule(int p, logic [ROW_W-1:0] row, logic [COL_W-1:0] col, logic [9:0] cfg);
    int en, half, typ, rc, cc, m, readStart, sampleAt;
    bit legal;
    en = cfg[0]; half = cfg[1]; typ = cfg[3:2]; rc = cfg[6:4]; cc = cfg[9:7];
    legal = (en == 1) && ((typ == 0 && cc >= 2 && cc <= 5) || (typ == 2 && cc >= 2 && cc <= 6));
    if (!legal) begin
      expErr[p] = 1'b1;   // R7: error pulse in the acceptance cycle's successor
      return;
    end
    m = half ? 2 : 1;
    readStart = (typ == 0) ? p + (rc + 1) * m : p + m;
    for (int c = p; c < p + m; c++) begin
      expCmd[c] = 1; expAddr[c] = ADDR_W'(row); expTag[c] = "R6";
    end
    for (int c = p + m; c < readStart; c++) expTag[c] = "R3";
    for (int c = readStart; c < readStart + m; c++) begin
      expCmd[c] = 2; expAddr[c] = ADDR_W'(col); expTag[c] = (typ == 0) ? "R3" : "R4";
    end
    sampleAt = readStart + (cc + 1) * m;
    for (int c = readStart + m; c <= sampleAt; c++) expTag[c] = "R5";
    expValid[sampleAt + 1] = 1'b1;
    expData[sampleAt + 1]  = pat(sampleAt);
    busyEnd = sampleAt + 1;
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) busyEnd = cyc;
    else if (reqValid && (cyc - 1 >= busyEnd)) schedule(cyc, reqRow, reqCol, cfgWord);
  end

  always @(negedge clk) memData <= pat(cyc);

  always @(negedge clk) begin : compare
    int eCmd;
    logic [ADDR_W-1:0] eAddr;
    string tag;
    bit eV, eE;
    if (cyc >= 1 && !done) begin
      eCmd  = expCmd.exists(cyc) ? expCmd[cyc] : 0;
      eAddr = expAddr.exists(cyc) ? expAddr[cyc] : '0;
      tag   = expTag.exists(cyc) ? expTag[cyc] : "R6";
      eV    = expValid.exists(cyc);
      eE    = expErr.exists(cyc);
      check(memCmd == 2'(eCmd), tag, "command", 64'(memCmd), 64'(eCmd));
      check(memAddr == eAddr, "R2", "address", 64'(memAddr), 64'(eAddr));
      check(reqReady == (cyc >= busyEnd), "R8", "ready", 64'(reqReady), 64'(cyc >= busyEnd));
      check(rdValid == eV, "R5", "valid", 64'(rdValid), 64'(eV));
      if (eV) check(rdData == expData[cyc], "R5", "data", 64'(rdData), 64'(expData[cyc]));
      check(rdError == eE, "R7", "error", 64'(rdError), 64'(eE));
    end
  end

  task automatic waitIdle();
    while (cyc < busyEnd) @(negedge clk);
  endtask

  task automatic access(logic [ROW_W-1:0] row, logic [COL_W-1:0] col, logic [9:0] cfg);
    waitIdle();
    @(negedge clk);
    reqValid = 1'b1; reqRow = row; reqCol = col; cfgWord = cfg;
    @(negedge clk);
    reqValid = 1'b0;
    waitIdle();
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(reqReady == 1'b1 && memCmd == 2'b00 && !rdValid && !rdError, "R1", "reset state",
          64'({reqReady, memCmd, rdValid, rdError}), 64'({1'b1, 2'b00, 1'b0, 1'b0}));
    rst = 1'b0;
    @(negedge clk);

    // R3 and R5: ROM at full rate, every row code
    for (int rc = 0; rc < 8; rc++)
      access(ROW_W'(100 + rc), COL_W'(7 * rc + 1), mk(1, 0, 0, rc, 2 + (rc % 4)));
    // R3, R5, R6: ROM at half rate
    for (int cc = 2; cc <= 5; cc++)
      access(ROW_W'(13'h1ABC - cc), COL_W'(10'h3F0 + cc), mk(1, 1, 0, cc + 1, cc));
    // R4: flash, row field at 111 and at other values, both rates
    for (int cc = 2; cc <= 6; cc++) begin
      access(ROW_W'(13'h0F00 + cc), COL_W'(cc), mk(1, 0, 2, 7, cc));
      access(ROW_W'(13'h1001 + cc), COL_W'(10'h2AA), mk(1, 1, 2, 7, cc));
    end
    access(ROW_W'(5), COL_W'(6), mk(1, 0, 2, 0, 3));
    access(ROW_W'(9), COL_W'(10), mk(1, 1, 2, 3, 4));

    // R7: refusals
    access(ROW_W'(1), COL_W'(1), mk(0, 0, 0, 1, 3));
    access(ROW_W'(1), COL_W'(1), mk(1, 0, 1, 1, 3));
    access(ROW_W'(1), COL_W'(1), mk(1, 1, 3, 1, 3));
    access(ROW_W'(2), COL_W'(2), mk(1, 0, 0, 1, 0));
    access(ROW_W'(2), COL_W'(2), mk(1, 0, 0, 1, 1));
    access(ROW_W'(2), COL_W'(2), mk(1, 0, 0, 1, 6));
    access(ROW_W'(2), COL_W'(2), mk(1, 0, 0, 1, 7));
    access(ROW_W'(3), COL_W'(3), mk(1, 0, 2, 7, 0));
    access(ROW_W'(3), COL_W'(3), mk(1, 0, 2, 7, 1));
    access(ROW_W'(3), COL_W'(3), mk(1, 0, 2, 7, 7));
    // a legal access right after refusals
    access(ROW_W'(4), COL_W'(4), mk(1, 0, 0, 2, 3));

    // R8: request held high across busy windows, row changing every cycle
    @(negedge clk);
    reqValid = 1'b1; cfgWord = mk(1, 0, 0, 1, 2);
    for (int i = 0; i < 40; i++) begin
      reqRow = ROW_W'(500 + i); reqCol = COL_W'(i);
      @(negedge clk);
    end
    reqValid = 1'b0;
    waitIdle();
    @(negedge clk);

    // R9: configuration rewritten in the middle of an access
    begin
      int p;
      int guard;
      waitIdle();
      @(negedge clk);
      reqValid = 1'b1; reqRow = ROW_W'(77); reqCol = COL_W'(88); cfgWord = mk(1, 0, 0, 3, 4);
      p = cyc + 1;
      @(negedge clk);
      reqValid = 1'b0;
      @(negedge clk);
      cfgWord = mk(1, 1, 2, 7, 6);
      guard = 0;
      while (!rdValid && guard < 50) begin
        @(negedge clk);
        guard++;
      end
      check(cyc == p + 10, "R9", "valid cycle after cfg change", 64'(cyc), 64'(p + 10));
      waitIdle();
      @(negedge clk);
    end

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule